// File: doc/BRIEF.md
# Transmit descriptor ring engine

This block is a bus-master transmitter. It walks a power-of-two ring of four-word transmit descriptors kept in a shared word-addressed memory. Any entry whose flag byte marks it as owned by the engine is fetched. The engine reads the entry's buffer address and length, streams the buffer out a byte at a time over a ready/valid port, and then writes a completion status word. It clears the ownership bit last, so the host gets the entry back only after its status is in place.

The host fills descriptors, sets their ownership bits and pulses a demand input to start a scan at once. With no demand, an idle engine re-polls its current entry at a fixed interval. Collision, retry, deferral and carrier outcomes are not produced here. They arrive on sideband inputs and are folded into the written-back flag and status fields. A one-cycle interrupt pulse follows every completed frame.

Top module: `txring_engine`

## Requirements
- R1: Descriptor i sits at word address (ring byte base / 2) + 4*i. Word 0 is the low 16 bits of the buffer byte address. Word 1 holds the flag byte in bits 15:8 and the high 8 address bits in bits 7:0. Word 2 is the length and word 3 is the status. The ring byte base is {ring_len_word[7:0], ring_base_lo}, and it must be a multiple of 8. ring_len_word bits 15:13 carry log2 of the entry count.
- R2: Only an entry whose flag bit 7 (0x80) is set is transmitted. The scan stops at the first entry without that bit and leaves that entry's words unchanged.
- R3: The frame length is the two's-complement negation of the low 12 bits of the length word (the top nibble is ignored). A result of zero sends no bytes but still completes the entry.
- R4: Byte k of a frame is read from buffer byte address {high, low} + k. An even byte address takes word bits 15:8 and an odd one takes bits 7:0. Each byte is offered with tx_valid, and tx_last marks the final byte. While tx_ready is low, tx_valid, tx_data and tx_last hold.
- R5: On completion the status word is written first and the flag word in the next cycle. The flag write clears bit 7 and keeps the address byte.
- R6: The written flag keeps start (0x02) and end (0x01) of packet and adds the following bits. Sideband retry code 1 sets 0x08 (one retry) and code 2 sets 0x10 (more than one). sb_deferred sets 0x04. Any error sets the summary bit 0x40.
- R7: The written status sets the following bits: 0x0400 for retry code 3 (failure after 16 tries), 0x0800 for sb_no_carrier, 0x1000 for sb_late_coll, and 0x8000 when the fetched flag lacked end-of-packet. Bits 9:0 and 0x4000 are zero. Each of these conditions is an error for R6, and a frame missing end-of-packet is still sent.
- R8: After the last ring entry the index wraps to entry 0, using a mask of entry-count minus one.
- R9: A tx_demand pulse starts a poll of the current entry within a few cycles. Without a demand, an idle engine polls again after POLL_CYCLES idle cycles and not before.
- R10: tx_irq is a one-cycle pulse in the cycle after each frame's flag write, and it is low out of reset.
- R11: The memory port never reads and writes in the same cycle. Read data is expected one cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base_lo | input | 16 | Low 16 bits of the ring byte address |
| ring_len_word | input | 16 | Bits 15:13 log2 entry count, bits 7:0 high ring address bits |
| tx_demand | input | 1 | Pulse: poll the current entry now |
| sb_retry | input | 2 | Retry outcome: 0 none, 1 one, 2 several, 3 gave up |
| sb_no_carrier | input | 1 | Carrier was lost during the frame |
| sb_late_coll | input | 1 | Late collision during the frame |
| sb_deferred | input | 1 | Frame was deferred |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | 23 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the request |
| tx_valid | output | 1 | Byte on tx_data is valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_irq | output | 1 | Frame-complete pulse |

## Verification
Several checks run on every cycle. The assertions confirm that a flag write is always directly preceded by the status write of the same descriptor, and that the interrupt follows a flag write that cleared ownership. They also check that a stalled byte holds its data and last marker, that the ring index wraps to zero from its top entry, and that reads and writes never share a cycle. Other behaviour can only be shown by the bench's scenarios:
- the byte order out of each buffer, including odd start addresses;
- the exact flag and status values for each sideband outcome;
- that a host-owned entry stops the scan untouched;
- that a zero length completes without bytes;
- that the periodic poll waits its interval when no demand is given.

// File: rtl/txr_pkg.sv
package txr_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_FLAG_RQ, S_FLAG_RS, S_BLO_RQ, S_BLO_RS, S_LEN_RQ, S_LEN_RS,
      S_DAT_RQ, S_DAT_RS, S_SEND, S_WSTAT, S_WFLAG
   } txr_state_t;

   localparam logic [7:0] FL_OWN  = 8'h80;
   localparam logic [7:0] FL_ERR  = 8'h40;
   localparam logic [7:0] FL_MULT = 8'h10;
   localparam logic [7:0] FL_ONE  = 8'h08;
   localparam logic [7:0] FL_DEF  = 8'h04;
   localparam logic [7:0] FL_STP  = 8'h02;
   localparam logic [7:0] FL_ENP  = 8'h01;
endpackage

// File: rtl/txr_poll_timer.sv
module txr_poll_timer #(
   parameter int POLL_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic demand,
   output logic poll_go
);
   localparam int CW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;

   initial begin
      if (POLL_CYCLES < 2) $error("POLL_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt;
   logic          pend;

   assign poll_go = run && (pend || demand || (cnt == CW'(POLL_CYCLES - 1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         if (!run || poll_go) cnt <= '0;
         else                 cnt <= cnt + 1'b1;
         if (poll_go)     pend <= 1'b0;
         else if (demand) pend <= 1'b1;
      end
   end
endmodule

// File: rtl/txr_ring_index.sv
module txr_ring_index #(
   parameter int MAX_LOG2 = 7,
   parameter int WAW      = 23
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [WAW-1:0]      base_w,
   input  logic [2:0]          log2_in,
   input  logic                advance,
   output logic [MAX_LOG2-1:0] idx,
   output logic [WAW-1:0]      desc_w
);
   initial begin
      if (MAX_LOG2 < 1 || MAX_LOG2 > 7) $error("MAX_LOG2 must be 1..7");
   end

   logic [2:0]          log2_eff;
   logic [MAX_LOG2:0]   span;
   logic [MAX_LOG2-1:0] mask;

   assign log2_eff = (32'(log2_in) > MAX_LOG2) ? 3'(MAX_LOG2) : log2_in;
   assign span     = (MAX_LOG2+1)'(1) << log2_eff;
   assign mask     = MAX_LOG2'(span - 1'b1);
   assign desc_w   = base_w + WAW'({idx, 2'b00});

   always_ff @(posedge clk) begin
      if (!rst_n)       idx <= '0;
      else if (advance) idx <= (idx + 1'b1) & mask;
   end

   // R8: stepping from the top entry lands on entry 0
   p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && idx == mask) |=> (idx == '0));
endmodule

// File: rtl/txr_status_pack.sv
module txr_status_pack
   import txr_pkg::*;
(
   input  logic [7:0]  flag_in,
   input  logic [1:0]  retry,
   input  logic        no_carrier,
   input  logic        late_coll,
   input  logic        deferred,
   output logic [7:0]  flag_out,
   output logic [15:0] stat_out
);
   logic no_end, gave_up, any_err;

   assign no_end  = !flag_in[0];
   assign gave_up = (retry == 2'd3);
   assign any_err = gave_up | no_carrier | late_coll | no_end;

   always_comb begin
      flag_out = flag_in & (FL_STP | FL_ENP);
      if (any_err)       flag_out = flag_out | FL_ERR;
      if (retry == 2'd1) flag_out = flag_out | FL_ONE;
      if (retry == 2'd2) flag_out = flag_out | FL_MULT;
      if (deferred)      flag_out = flag_out | FL_DEF;
      stat_out = {no_end, 1'b0, 1'b0, late_coll, no_carrier, gave_up, 10'd0};
   end
endmodule

// File: rtl/txring_engine.sv
module txring_engine
   import txr_pkg::*;
#(
   parameter int POLL_CYCLES = 1024,
   parameter int MAX_LOG2    = 7,
   parameter bit BYTE_SWAP   = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] ring_base_lo,
   input  logic [15:0] ring_len_word,
   input  logic        tx_demand,
   input  logic [1:0]  sb_retry,
   input  logic        sb_no_carrier,
   input  logic        sb_late_coll,
   input  logic        sb_deferred,
   output logic        mem_rd_en,
   output logic        mem_wr_en,
   output logic [22:0] mem_addr,
   output logic [15:0] mem_wdata,
   input  logic [15:0] mem_rdata,
   output logic        tx_valid,
   output logic [7:0]  tx_data,
   output logic        tx_last,
   input  logic        tx_ready,
   output logic        tx_irq
);
   localparam int BAW = 24;
   localparam int WAW = BAW - 1;
   localparam int LW  = 12;

   txr_state_t    st;
   logic [7:0]    flag_r, bhi_r, byte_r, flag_new_r;
   logic [15:0]   blo_r;
   logic [LW-1:0] len_r, cnt_r;
   logic          irq_r;
   logic          poll_go, advance;
   logic [BAW-1:0] ring_byte, buf_byte;
   logic [WAW-1:0] desc_w;
   logic [MAX_LOG2-1:0] idx;
   logic [7:0]    lane, flag_pk;
   logic [15:0]   stat_pk;
   logic [LW-1:0] len_dec;

   assign ring_byte = {ring_len_word[7:0], ring_base_lo};
   assign buf_byte  = {bhi_r, blo_r} + BAW'(cnt_r);
   assign advance   = (st == S_WFLAG);
   assign len_dec   = (~mem_rdata[LW-1:0]) + 1'b1;

   txr_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_poll (
      .clk(clk), .rst_n(rst_n), .run(st == S_IDLE), .demand(tx_demand),
      .poll_go(poll_go));

   txr_ring_index #(.MAX_LOG2(MAX_LOG2), .WAW(WAW)) u_idx (
      .clk(clk), .rst_n(rst_n), .base_w(ring_byte[BAW-1:1]),
      .log2_in(ring_len_word[15:13]), .advance(advance),
      .idx(idx), .desc_w(desc_w));

   txr_status_pack u_pack (
      .flag_in(flag_r), .retry(sb_retry), .no_carrier(sb_no_carrier),
      .late_coll(sb_late_coll), .deferred(sb_deferred),
      .flag_out(flag_pk), .stat_out(stat_pk));

   generate
      if (BYTE_SWAP) begin : g_lane_swap
         assign lane = buf_byte[0] ? mem_rdata[15:8] : mem_rdata[7:0];
      end else begin : g_lane_norm
         assign lane = buf_byte[0] ? mem_rdata[7:0] : mem_rdata[15:8];
      end
   endgenerate

   always_comb begin
      mem_rd_en = 1'b0;
      mem_wr_en = 1'b0;
      mem_addr  = desc_w;
      mem_wdata = '0;
      case (st)
         S_FLAG_RQ: begin mem_rd_en = 1'b1; mem_addr = desc_w + WAW'(1); end
         S_BLO_RQ:  begin mem_rd_en = 1'b1; mem_addr = desc_w; end
         S_LEN_RQ:  begin mem_rd_en = 1'b1; mem_addr = desc_w + WAW'(2); end
         S_DAT_RQ:  begin mem_rd_en = 1'b1; mem_addr = buf_byte[BAW-1:1]; end
         S_WSTAT:   begin mem_wr_en = 1'b1; mem_addr = desc_w + WAW'(3);
                          mem_wdata = stat_pk; end
         S_WFLAG:   begin mem_wr_en = 1'b1; mem_addr = desc_w + WAW'(1);
                          mem_wdata = {flag_new_r, bhi_r}; end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         flag_r     <= '0;
         bhi_r      <= '0;
         blo_r      <= '0;
         len_r      <= '0;
         cnt_r      <= '0;
         byte_r     <= '0;
         flag_new_r <= '0;
         irq_r      <= 1'b0;
      end else begin
         irq_r <= (st == S_WFLAG);
         case (st)
            S_IDLE:    if (poll_go) st <= S_FLAG_RQ;
            S_FLAG_RQ: st <= S_FLAG_RS;
            S_FLAG_RS: begin
               flag_r <= mem_rdata[15:8];
               bhi_r  <= mem_rdata[7:0];
               st     <= mem_rdata[15] ? S_BLO_RQ : S_IDLE;
            end
            S_BLO_RQ:  st <= S_BLO_RS;
            S_BLO_RS:  begin blo_r <= mem_rdata; st <= S_LEN_RQ; end
            S_LEN_RQ:  st <= S_LEN_RS;
            S_LEN_RS: begin
               len_r <= len_dec;
               cnt_r <= '0;
               st    <= (len_dec == '0) ? S_WSTAT : S_DAT_RQ;
            end
            S_DAT_RQ:  st <= S_DAT_RS;
            S_DAT_RS:  begin byte_r <= lane; st <= S_SEND; end
            S_SEND: if (tx_ready) begin
               cnt_r <= cnt_r + 1'b1;
               st    <= tx_last ? S_WSTAT : S_DAT_RQ;
            end
            S_WSTAT: begin flag_new_r <= flag_pk; st <= S_WFLAG; end
            S_WFLAG: st <= S_FLAG_RQ;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign tx_valid = (st == S_SEND);
   assign tx_data  = byte_r;
   assign tx_last  = (st == S_SEND) && (cnt_r == len_r - 1'b1);
   assign tx_irq   = irq_r;

   // R5: a flag-word write comes right after the status-word write
   p_status_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && mem_addr[1:0] == 2'b01) |->
      $past(mem_wr_en && mem_addr[1:0] == 2'b11));

   // R10: the interrupt follows a write that handed the entry back
   p_irq_after_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> ($past(mem_wr_en) && !$past(mem_wdata[15])));

   // R4: a stalled byte is held unchanged
   p_hold_on_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

   // R11: one memory direction per cycle
   p_one_direction_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));
endmodule

// File: tb/txring_engine_test.sv
module txring_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int POLL       = 200;
   localparam int DW         = 'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ring_base_lo = 16'h0080;
   logic [15:0] ring_len_word = {3'd2, 13'd0};
   logic        tx_demand = 1'b0;
   logic [1:0]  sb_retry = 2'd0;
   logic        sb_no_carrier = 1'b0, sb_late_coll = 1'b0, sb_deferred = 1'b0;
   logic        mem_rd_en, mem_wr_en;
   logic [22:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = 16'h0;
   logic        tx_valid, tx_last, tx_irq;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b1;

   int nchk = 0, nfail = 0, irq_cnt = 0, rw_clash = 0, rcyc = 0;
   bit finished = 1'b0;
   logic [15:0] mem [0:1023];
   logic [8:0]  expq [$];
   logic        prev_stall = 1'b0;
   logic [8:0]  prev_item = 9'h0;

   always #(CLK_PERIOD/2) clk = ~clk;

   txring_engine #(.POLL_CYCLES(POLL), .MAX_LOG2(7), .BYTE_SWAP(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .ring_base_lo(ring_base_lo),
      .ring_len_word(ring_len_word), .tx_demand(tx_demand), .sb_retry(sb_retry),
      .sb_no_carrier(sb_no_carrier), .sb_late_coll(sb_late_coll),
      .sb_deferred(sb_deferred), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
      .tx_ready(tx_ready), .tx_irq(tx_irq));

   always @(posedge clk) begin
      if (mem_rd_en) mem_rdata <= mem[mem_addr[9:0]];
      if (mem_wr_en) mem[mem_addr[9:0]] <= mem_wdata;
   end

   always @(posedge clk) begin
      #1;
      rcyc = rcyc + 1;
      tx_ready = (rcyc % 4 != 2);
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_irq) irq_cnt++;
         if (mem_rd_en && mem_wr_en) rw_clash++;
         if (prev_stall) begin
            chk("R4 stalled byte held", {23'd0, tx_valid, tx_last, tx_data},
                {23'd0, 1'b1, prev_item});
         end
         prev_stall = tx_valid && !tx_ready;
         prev_item  = {tx_last, tx_data};
         if (tx_valid && tx_ready) begin
            if (expq.size() == 0) begin
               chk("R2 unexpected byte", {23'd0, tx_last, tx_data}, 32'h1FF);
            end else begin
               logic [8:0] e;
               e = expq.pop_front();
               chk("R4 stream byte", {23'd0, tx_last, tx_data}, {23'd0, e});
            end
         end
      end
   end

   function automatic logic [7:0] pat(input int a);
      return 8'(a * 7 + 13) ^ 8'h5A;
   endfunction

   task automatic put_desc(input int idx, input logic [7:0] flag, input int n,
                           input int baddr);
      int d;
      logic [15:0] lw;
      d = DW + 4 * idx;
      for (int k = 0; k < n; k++) begin
         int a;
         a = baddr + k;
         if (a % 2 == 0) mem[a / 2][15:8] = pat(a);
         else            mem[a / 2][7:0]  = pat(a);
         if (flag[7]) expq.push_back({(k == n - 1), pat(a)});
      end
      lw = 16'h0000 - 16'(n);
      lw[15:12] = 4'hF;
      mem[d]     = 16'(baddr);
      mem[d + 2] = lw;
      mem[d + 3] = 16'hBEEF;
      mem[d + 1] = {flag, 8'h00};
   endtask

   task automatic pulse_demand();
      @(posedge clk); #1 tx_demand = 1'b1;
      @(posedge clk); #1 tx_demand = 1'b0;
   endtask

   task automatic wait_valid(input int lim, output int took);
      took = 0;
      while (!tx_valid && took < lim) begin
         @(negedge clk);
         took++;
      end
   endtask

   task automatic wait_irq(input int n);
      int t;
      t = 0;
      while (irq_cnt < n && t < 3000) begin
         @(negedge clk);
         t++;
      end
      repeat (10) @(negedge clk);
   endtask

   task automatic chk_desc(input string req, input int idx, input logic [7:0] fl,
                           input logic [15:0] st);
      chk({req, " flag word"}, {16'd0, mem[DW + 4 * idx + 1]}, {16'd0, fl, 8'h00});
      chk({req, " status word"}, {16'd0, mem[DW + 4 * idx + 3]}, {16'd0, st});
   endtask

   initial begin
      int took;
      for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10 reset irq low", {31'd0, tx_irq}, 32'd0);
      chk("R4 reset valid low", {31'd0, tx_valid}, 32'd0);
      chk("R11 reset memory idle", {30'd0, mem_rd_en, mem_wr_en}, 32'd0);
      @(posedge clk); #1 rst_n = 1'b1;

      // S1: two owned entries, a host-owned third stops the scan
      put_desc(0, 8'h83, 3, 'h200);
      put_desc(1, 8'h83, 5, 'h240);
      mem[DW + 11] = 16'hBEEF;
      mem[DW + 9]  = 16'h0300;
      pulse_demand();
      wait_valid(20, took);
      chk("R9 demand starts poll promptly", {31'd0, (took < 20)}, 32'd1);
      wait_irq(2);
      chk("R4 S1 queue drained", expq.size(), 0);
      chk_desc("R1 R5 entry0", 0, 8'h03, 16'h0000);
      chk_desc("R3 R5 entry1", 1, 8'h03, 16'h0000);
      chk_desc("R2 entry2 untouched", 2, 8'h03, 16'hBEEF);
      chk("R10 two pulses", irq_cnt, 2);

      // S2: one retry plus deferral
      sb_retry = 2'd1; sb_deferred = 1'b1;
      put_desc(2, 8'h83, 4, 'h280);
      pulse_demand();
      wait_irq(3);
      chk_desc("R6 one retry deferred", 2, 8'h0F, 16'h0000);

      // S3: late collision and lost carrier
      sb_retry = 2'd0; sb_deferred = 1'b0; sb_late_coll = 1'b1; sb_no_carrier = 1'b1;
      put_desc(3, 8'h83, 2, 'h2C0);
      pulse_demand();
      wait_irq(4);
      chk_desc("R7 late coll no carrier", 3, 8'h43, 16'h1800);

      // S4: wrap to entry 0, retries exhausted
      sb_late_coll = 1'b0; sb_no_carrier = 1'b0; sb_retry = 2'd3;
      put_desc(0, 8'h83, 1, 'h200);
      pulse_demand();
      wait_irq(5);
      chk_desc("R8 wrapped entry0 retry fail", 0, 8'h43, 16'h0400);

      // S5: missing end-of-packet, frame still sent
      sb_retry = 2'd0;
      put_desc(1, 8'h82, 3, 'h240);
      pulse_demand();
      wait_irq(6);
      chk("R7 S5 bytes sent", expq.size(), 0);
      chk_desc("R7 no end of packet", 1, 8'h42, 16'h8000);

      // S6: periodic poll, zero length then odd-address buffer
      sb_retry = 2'd2;
      put_desc(2, 8'h83, 0, 'h280);
      put_desc(3, 8'h83, 6, 'h301);
      took = 0;
      repeat (30) begin
         @(negedge clk);
         if (tx_valid || irq_cnt != 6) took++;
      end
      chk("R9 no poll before interval", took, 0);
      wait_valid(400, took);
      chk("R9 periodic poll fires", {31'd0, (took < 400)}, 32'd1);
      wait_irq(8);
      chk("R4 S6 queue drained", expq.size(), 0);
      chk_desc("R3 zero length completes", 2, 8'h13, 16'h0000);
      chk_desc("R6 several retries", 3, 8'h13, 16'h0000);
      chk("R10 total pulses", irq_cnt, 8);
      chk("R11 no read-write clash", rw_clash, 0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule